// File: doc/BRIEF.md
# Four-Slot Scanline Ring Buffer

This block keeps four scanline slots on chip and sits between an engine that fetches pixels from external memory and a pixel streamer that drives the display. Three line positions move through the four slots together. The streamer reads line N. Line N+1 is open for a sprite overlay that reads and rewrites single pixels. The fetch engine loads line N+2. A line lives in slot `line mod 4`. Each accepted horizontal sync moves every position forward by one slot.

The read pointer covers the whole ring, and the ring is sized so that it holds a multiple of 64 bytes. If the streamer keeps pulling pixels past the end of a line, it runs into the next slot, and from slot 3 back to slot 0, without being restarted. A vertical sync clears the ring and primes it by requesting lines 0 and 1 before the first visible line. If the line that is about to be shown was not fully loaded in time, a sticky underrun flag is raised.

The controller is a five-state machine:
- `ST_IDLE`: reset state, waiting for a vertical sync.
- `ST_PRIME0`: requests line 0 into slot 0.
- `ST_PRIME1`: requests line 1 into slot 1.
- `ST_RUN`: streaming, with no request outstanding.
- `ST_REQ`: streaming, with a request for line N+2 outstanding.

Its transitions are:
- vsync, from any state, goes to `ST_PRIME0`.
- An accepted request moves `ST_PRIME0` to `ST_PRIME1`, `ST_PRIME1` to `ST_RUN`, and `ST_REQ` to `ST_RUN`.
- hsync moves `ST_RUN` to `ST_REQ`. In `ST_REQ`, hsync keeps the state and replaces the request.
- hsync is ignored in `ST_IDLE`, `ST_PRIME0` and `ST_PRIME1`.

Top module: `scanline_ring`

## Requirements
- R1: After reset there is no fill request, the underrun flag is low and the stream slot reads 3, so the first accepted hsync moves it to slot 0.
- R2: One cycle after a vsync, a request for line 0 into slot 0 is shown. It is held until `fill_ack_i`. Line 1 into slot 1 is then requested in the same way. `fill_req_o` stays low while an acknowledged fill has not yet signalled done.
- R3: An hsync in the running states advances the stream slot by one (mod 4) on the next cycle. From then on, while no fill is open, it requests line N+2 into slot (N+2) mod 4, where N is the new stream line.
- R4: Fill writes are taken only while a fill is open, and they land in the slot of the last acknowledged request at pixel index `fill_addr_i`.
- R5: Each cycle with `pix_en_i` high, `pix_o` shows the ring word at the read pointer on the next cycle, and the pointer advances. It runs from the last pixel of a slot into pixel 0 of the next slot, and from slot 3 into slot 0.
- R6: An accepted hsync reloads the read pointer to pixel 0 of the new stream slot. A vsync reloads it to pixel 0 of slot 3.
- R7: `ov_ok_o` is high only when `ov_slot_i` is neither the stream slot nor the slot of an open fill. An allowed overlay read returns the stored pixel one cycle later, and an allowed write updates it.
- R8: Overlay writes aimed at the stream slot or at an open-fill slot change nothing.
- R9: An accepted hsync whose new stream slot has not completed a fill since that slot was last streamed sets `underrun_o`. The flag stays high until the next vsync, which clears it.
- R10: hsync has no effect on the stream slot or on the request while in `ST_IDLE`, `ST_PRIME0` or `ST_PRIME1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Frame start pulse |
| hsync_i | input | 1 | Line start pulse |
| fill_req_o | output | 1 | Line load request valid |
| fill_line_o | output | LINE_W | Line number requested |
| fill_slot_o | output | 2 | Slot the requested line goes into |
| fill_ack_i | input | 1 | Request accepted; fill opens |
| fill_we_i | input | 1 | Fill pixel write strobe |
| fill_addr_i | input | log2(LINE_PIX) | Pixel index of the fill write |
| fill_data_i | input | PIX_W | Fill pixel value |
| fill_done_i | input | 1 | Open fill complete |
| ov_slot_i | input | 2 | Overlay target slot |
| ov_addr_i | input | log2(LINE_PIX) | Overlay pixel index |
| ov_rd_i | input | 1 | Overlay read strobe |
| ov_we_i | input | 1 | Overlay write strobe |
| ov_wdata_i | input | PIX_W | Overlay write value |
| ov_ok_o | output | 1 | Overlay access to `ov_slot_i` allowed |
| ov_rdata_o | output | PIX_W | Overlay read data (zero if blocked) |
| pix_en_i | input | 1 | Pixel pull enable |
| pix_o | output | PIX_W | Streamed pixel |
| stream_slot_o | output | 2 | Slot of the line being streamed |
| underrun_o | output | 1 | Sticky late-fill flag |

## Verification
The per-cycle properties cover the following:
- the stream slot stepping on each accepted hsync;
- the request being held until it is acknowledged;
- the request being kept two slots ahead of the stream slot;
- the sticky behaviour of the underrun flag;
- hsync being ignored while priming;
- the read pointer stepping and reloading;
- fill and overlay writes never sharing a slot.

Only the bench scenarios can show that pixel values come out in the right order across slot and ring wraps. They also show that overlay read-modify-writes and rejected writes leave the intended contents, and that a skipped fill turns into an underrun exactly two lines later.

// File: rtl/scanring_pkg.sv
package scanring_pkg;

    localparam int unsigned SLOT_CNT = 4;
    localparam int unsigned SLOT_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME0,
        ST_PRIME1,
        ST_RUN,
        ST_REQ
    } ring_state_t;

endpackage

// File: rtl/scanring_ctrl.sv
module scanring_ctrl
    import scanring_pkg::*;
#(
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              hsync_i,
    input  logic              fill_ack_i,
    input  logic              fill_done_i,
    output logic              fill_req_o,
    output logic [LINE_W-1:0] fill_line_o,
    output logic [SLOT_W-1:0] fill_slot_o,
    output logic [SLOT_W-1:0] stream_slot_o,
    output logic              fill_busy_o,
    output logic [SLOT_W-1:0] busy_slot_o,
    output logic              ptr_ld_o,
    output logic [SLOT_W-1:0] ptr_slot_o,
    output logic              underrun_o
);

    ring_state_t         state, state_nxt;
    logic [LINE_W-1:0]   cur_line;
    logic [LINE_W-1:0]   req_line;
    logic [SLOT_W-1:0]   req_slot;
    logic [SLOT_W-1:0]   strm_slot;
    logic [SLOT_W-1:0]   nxt_slot;
    logic [SLOT_CNT-1:0] ready;
    logic                busy;
    logic [SLOT_W-1:0]   busy_slot;
    logic                under_q;
    logic                hs_take;
    logic                ack_take;
    logic                req_state;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = ST_IDLE;
            ST_PRIME0: if (ack_take) state_nxt = ST_PRIME1;
            ST_PRIME1: if (ack_take) state_nxt = ST_RUN;
            ST_RUN:    if (hs_take) state_nxt = ST_REQ;
            ST_REQ:    if (ack_take && !hs_take) state_nxt = ST_RUN;
        endcase
        if (vsync_i) state_nxt = ST_PRIME0;
    end

    // outputs derived from state
    always_comb begin
        req_state = 1'b0;
        hs_take   = 1'b0;
        unique case (state)
            ST_IDLE:   begin req_state = 1'b0; hs_take = 1'b0;    end
            ST_PRIME0: begin req_state = 1'b1; hs_take = 1'b0;    end
            ST_PRIME1: begin req_state = 1'b1; hs_take = 1'b0;    end
            ST_RUN:    begin req_state = 1'b0; hs_take = hsync_i; end
            ST_REQ:    begin req_state = 1'b1; hs_take = hsync_i; end
        endcase
        nxt_slot   = strm_slot + SLOT_W'(1);
        fill_req_o = req_state && !busy;
        ack_take   = fill_ack_i && fill_req_o;
        ptr_ld_o   = vsync_i || hs_take;
        ptr_slot_o = vsync_i ? SLOT_W'(SLOT_CNT - 1) : nxt_slot;
    end

    // line, slot and readiness bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || vsync_i) begin
            strm_slot <= SLOT_W'(SLOT_CNT - 1);
            cur_line  <= '1;
            req_line  <= '0;
            req_slot  <= '0;
            ready     <= '0;
            busy      <= 1'b0;
            busy_slot <= '0;
            under_q   <= 1'b0;
        end else begin
            if (fill_done_i && busy) begin
                ready[busy_slot] <= 1'b1;
                busy             <= 1'b0;
            end
            if (ack_take) begin
                busy            <= 1'b1;
                busy_slot       <= req_slot;
                ready[req_slot] <= 1'b0;
                if (state == ST_PRIME0) begin
                    req_line <= LINE_W'(1);
                    req_slot <= SLOT_W'(1);
                end
            end
            if (hs_take) begin
                strm_slot        <= nxt_slot;
                cur_line         <= cur_line + LINE_W'(1);
                req_line         <= cur_line + LINE_W'(3);
                req_slot         <= strm_slot + SLOT_W'(3);
                ready[strm_slot] <= 1'b0;
                if (!ready[nxt_slot]) under_q <= 1'b1;
            end
        end
    end

    assign fill_line_o   = req_line;
    assign fill_slot_o   = req_slot;
    assign stream_slot_o = strm_slot;
    assign fill_busy_o   = busy;
    assign busy_slot_o   = busy_slot;
    assign underrun_o    = under_q;

    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_take && !vsync_i) |=> stream_slot_o == SLOT_W'($past(stream_slot_o) + SLOT_W'(1)));

    assert_req_ahead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ) |-> fill_slot_o == SLOT_W'(stream_slot_o + SLOT_W'(2)));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_o && !fill_ack_i && !vsync_i && !hsync_i)
        |=> (fill_req_o && $stable(fill_line_o) && $stable(fill_slot_o)));

    assert_underrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_o && !vsync_i) |=> underrun_o);

    assert_prime_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_i && !vsync_i && (state == ST_IDLE || state == ST_PRIME0 || state == ST_PRIME1))
        |=> $stable(stream_slot_o));

endmodule

// File: rtl/scanring_gate.sv
module scanring_gate
    import scanring_pkg::*;
(
    input  logic              ov_rd_i,
    input  logic              ov_we_i,
    input  logic [SLOT_W-1:0] ov_slot_i,
    input  logic [SLOT_W-1:0] stream_slot_i,
    input  logic              fill_busy_i,
    input  logic [SLOT_W-1:0] busy_slot_i,
    output logic              ov_ok_o,
    output logic              ov_rd_o,
    output logic              ov_we_o
);

    logic hits_stream;
    logic hits_fill;

    always_comb begin
        hits_stream = (ov_slot_i == stream_slot_i);
        hits_fill   = fill_busy_i && (ov_slot_i == busy_slot_i);
        ov_ok_o     = !hits_stream && !hits_fill;
        ov_rd_o     = ov_rd_i && ov_ok_o;
        ov_we_o     = ov_we_i && ov_ok_o;
    end

endmodule

// File: rtl/scanring_store.sv
module scanring_store
    import scanring_pkg::*;
#(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned LINE_PIX = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_we_i,
    input  logic [SLOT_W-1:0]            fill_slot_i,
    input  logic [$clog2(LINE_PIX)-1:0]  fill_addr_i,
    input  logic [PIX_W-1:0]             fill_data_i,
    input  logic                         ov_rd_i,
    input  logic                         ov_ok_i,
    input  logic                         ov_we_i,
    input  logic [SLOT_W-1:0]            ov_slot_i,
    input  logic [$clog2(LINE_PIX)-1:0]  ov_addr_i,
    input  logic [PIX_W-1:0]             ov_wdata_i,
    output logic [PIX_W-1:0]             ov_rdata_o,
    input  logic                         pix_en_i,
    input  logic                         ptr_ld_i,
    input  logic [SLOT_W-1:0]            ptr_slot_i,
    output logic [PIX_W-1:0]             pix_o
);

    localparam int unsigned PIX_AW  = $clog2(LINE_PIX);
    localparam int unsigned RING_AW = PIX_AW + SLOT_W;
    localparam int unsigned DEPTH   = SLOT_CNT * LINE_PIX;

    logic [PIX_W-1:0]   mem [DEPTH];
    logic [RING_AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (fill_we_i) mem[{fill_slot_i, fill_addr_i}] <= fill_data_i;
        if (ov_we_i)   mem[{ov_slot_i, ov_addr_i}]     <= ov_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr     <= '0;
            pix_o      <= '0;
            ov_rdata_o <= '0;
        end else begin
            if (ptr_ld_i)      rd_ptr <= {ptr_slot_i, PIX_AW'(0)};
            else if (pix_en_i) rd_ptr <= rd_ptr + RING_AW'(1);
            if (pix_en_i) pix_o <= mem[rd_ptr];
            if (ov_rd_i)  ov_rdata_o <= ov_ok_i ? mem[{ov_slot_i, ov_addr_i}] : '0;
        end
    end

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && !ptr_ld_i) |=> rd_ptr == RING_AW'($past(rd_ptr) + RING_AW'(1)));

    assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld_i |=> rd_ptr[PIX_AW-1:0] == '0);

    assert_write_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_i && ov_we_i) |-> ov_slot_i != fill_slot_i);

endmodule

// File: rtl/scanline_ring.sv
module scanline_ring
    import scanring_pkg::*;
#(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned LINE_PIX = 16,
    parameter int unsigned LINE_W   = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vsync_i,
    input  logic                        hsync_i,
    output logic                        fill_req_o,
    output logic [LINE_W-1:0]           fill_line_o,
    output logic [1:0]                  fill_slot_o,
    input  logic                        fill_ack_i,
    input  logic                        fill_we_i,
    input  logic [$clog2(LINE_PIX)-1:0] fill_addr_i,
    input  logic [PIX_W-1:0]            fill_data_i,
    input  logic                        fill_done_i,
    input  logic [1:0]                  ov_slot_i,
    input  logic [$clog2(LINE_PIX)-1:0] ov_addr_i,
    input  logic                        ov_rd_i,
    input  logic                        ov_we_i,
    input  logic [PIX_W-1:0]            ov_wdata_i,
    output logic                        ov_ok_o,
    output logic [PIX_W-1:0]            ov_rdata_o,
    input  logic                        pix_en_i,
    output logic [PIX_W-1:0]            pix_o,
    output logic [1:0]                  stream_slot_o,
    output logic                        underrun_o
);

    logic              fill_busy;
    logic [SLOT_W-1:0] busy_slot;
    logic              ptr_ld;
    logic [SLOT_W-1:0] ptr_slot;
    logic              ov_rd_ok;
    logic              ov_we_ok;
    logic              fill_we_ok;

    scanring_ctrl #(.LINE_W(LINE_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .vsync_i       (vsync_i),
        .hsync_i       (hsync_i),
        .fill_ack_i    (fill_ack_i),
        .fill_done_i   (fill_done_i),
        .fill_req_o    (fill_req_o),
        .fill_line_o   (fill_line_o),
        .fill_slot_o   (fill_slot_o),
        .stream_slot_o (stream_slot_o),
        .fill_busy_o   (fill_busy),
        .busy_slot_o   (busy_slot),
        .ptr_ld_o      (ptr_ld),
        .ptr_slot_o    (ptr_slot),
        .underrun_o    (underrun_o)
    );

    scanring_gate u_gate (
        .ov_rd_i       (ov_rd_i),
        .ov_we_i       (ov_we_i),
        .ov_slot_i     (ov_slot_i),
        .stream_slot_i (stream_slot_o),
        .fill_busy_i   (fill_busy),
        .busy_slot_i   (busy_slot),
        .ov_ok_o       (ov_ok_o),
        .ov_rd_o       (ov_rd_ok),
        .ov_we_o       (ov_we_ok)
    );

    assign fill_we_ok = fill_we_i && fill_busy;

    scanring_store #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_we_i   (fill_we_ok),
        .fill_slot_i (busy_slot),
        .fill_addr_i (fill_addr_i),
        .fill_data_i (fill_data_i),
        .ov_rd_i     (ov_rd_i),
        .ov_ok_i     (ov_rd_ok),
        .ov_we_i     (ov_we_ok),
        .ov_slot_i   (ov_slot_i),
        .ov_addr_i   (ov_addr_i),
        .ov_wdata_i  (ov_wdata_i),
        .ov_rdata_o  (ov_rdata_o),
        .pix_en_i    (pix_en_i),
        .ptr_ld_i    (ptr_ld),
        .ptr_slot_i  (ptr_slot),
        .pix_o       (pix_o)
    );

    assert_ov_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov_we_ok |-> ov_slot_i != stream_slot_o);

endmodule

// File: tb/tb_scanline_ring.sv
module tb_scanline_ring;

    localparam int PIX_W    = 8;
    localparam int LINE_PIX = 16;
    localparam int LINE_W   = 11;
    localparam int NV       = 8;

    // each row: {overlay pixel index, xor value}
    localparam logic [15:0] VEC [NV] = '{
        16'h035A, 16'h0FFF, 16'h0001, 16'h0780,
        16'h0A3C, 16'h01C3, 16'h0E10, 16'h0566
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 1'b0, hsync = 1'b0;
    logic fill_req;
    logic [LINE_W-1:0] fill_line;
    logic [1:0] fill_slot;
    logic fill_ack = 1'b0, fill_we = 1'b0, fill_done = 1'b0;
    logic [3:0] fill_addr = '0;
    logic [7:0] fill_data = '0;
    logic [1:0] ov_slot = '0;
    logic [3:0] ov_addr = '0;
    logic ov_rd = 1'b0, ov_we = 1'b0;
    logic [7:0] ov_wdata = '0;
    logic ov_ok;
    logic [7:0] ov_rdata;
    logic pix_en = 1'b0;
    logic [7:0] pix;
    logic [1:0] stream_slot;
    logic underrun;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ref_m [4][LINE_PIX];

    always #10 clk = ~clk;

    scanline_ring #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .LINE_W(LINE_W)) dut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .hsync_i(hsync),
        .fill_req_o(fill_req), .fill_line_o(fill_line), .fill_slot_o(fill_slot),
        .fill_ack_i(fill_ack), .fill_we_i(fill_we), .fill_addr_i(fill_addr),
        .fill_data_i(fill_data), .fill_done_i(fill_done),
        .ov_slot_i(ov_slot), .ov_addr_i(ov_addr), .ov_rd_i(ov_rd), .ov_we_i(ov_we),
        .ov_wdata_i(ov_wdata), .ov_ok_o(ov_ok), .ov_rdata_o(ov_rdata),
        .pix_en_i(pix_en), .pix_o(pix), .stream_slot_o(stream_slot), .underrun_o(underrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fpat(input int line, input int p);
        return 8'((line * 17 + p) ^ 8'hA5);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_hs();
        hsync = 1'b1; step(); hsync = 1'b0;
    endtask

    task automatic pulse_vs();
        vsync = 1'b1; step(); vsync = 1'b0;
    endtask

    // serve one line request; optionally poke the open-fill slot (must be ignored)
    task automatic serve(input int line, input int slot, input bit poke);
        chk("R2 req", 32'(fill_req), 1);
        chk("R3 line", 32'(fill_line), 32'(line));
        chk("R3 slot", 32'(fill_slot), 32'(slot));
        fill_ack = 1'b1; step(); fill_ack = 1'b0;
        chk("R2 req low while open", 32'(fill_req), 0);
        for (int p = 0; p < LINE_PIX; p++) begin
            fill_we = 1'b1; fill_addr = 4'(p); fill_data = fpat(line, p);
            step();
            ref_m[slot][p] = fpat(line, p);
        end
        fill_we = 1'b0;
        if (poke) begin
            ov_slot = 2'(slot); ov_addr = 4'd0; #1;
            chk("R7 fill slot blocked", 32'(ov_ok), 0);
            ov_we = 1'b1; ov_wdata = 8'hEE; step(); ov_we = 1'b0;
        end
        fill_done = 1'b1; step(); fill_done = 1'b0;
        // a write strobe after done must not land (R4)
        fill_we = 1'b1; fill_addr = 4'd1; fill_data = 8'h00; step(); fill_we = 1'b0;
    endtask

    task automatic stream(input int slot, input int n);
        pix_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            step();
            if (i == 0)
                chk("R6 reload", 32'(pix), 32'(ref_m[slot][0]));
            else if (i < LINE_PIX)
                chk("R4 pixel", 32'(pix), 32'(ref_m[slot][i]));
            else
                chk("R5 wrap", 32'(pix), 32'(ref_m[(slot + i / LINE_PIX) % 4][i % LINE_PIX]));
        end
        pix_en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 req", 32'(fill_req), 0);
        chk("R1 slot", 32'(stream_slot), 3);
        chk("R1 underrun", 32'(underrun), 0);

        pulse_hs();
        chk("R10 idle slot", 32'(stream_slot), 3);
        chk("R10 idle req", 32'(fill_req), 0);

        pulse_vs();
        serve(0, 0, 0);
        pulse_hs();
        chk("R10 prime slot", 32'(stream_slot), 3);
        serve(1, 1, 0);

        for (int k = 0; k < NV; k++) begin
            int s, c, ix;
            logic [7:0] rd;
            s = k % 4;
            c = (k + 1) % 4;
            pulse_hs();
            chk("R3 stream slot", 32'(stream_slot), 32'(s));
            chk("R9 no underrun", 32'(underrun), 0);
            serve(k + 2, (k + 2) % 4, 1);
            ov_slot = 2'(s); ov_addr = 4'd2; #1;
            chk("R7 stream slot blocked", 32'(ov_ok), 0);
            ov_we = 1'b1; ov_wdata = 8'h77; step(); ov_we = 1'b0;
            ix = int'(VEC[k][11:8]);
            ov_slot = 2'(c); ov_addr = 4'(ix); #1;
            chk("R7 compose slot open", 32'(ov_ok), 1);
            ov_rd = 1'b1; step(); ov_rd = 1'b0;
            rd = ov_rdata;
            chk("R7 overlay read", 32'(rd), 32'(ref_m[c][ix]));
            ov_we = 1'b1; ov_wdata = rd ^ VEC[k][7:0]; step(); ov_we = 1'b0;
            ref_m[c][ix] = rd ^ VEC[k][7:0];
            stream(s, LINE_PIX + 4);
        end

        pulse_hs();
        chk("R9 line8 ok", 32'(underrun), 0);
        pulse_hs();
        chk("R9 line9 ok", 32'(underrun), 0);
        pulse_hs();
        chk("R9 late fill", 32'(underrun), 1);
        pulse_hs();
        chk("R9 sticky", 32'(underrun), 1);
        pulse_vs();
        chk("R9 vsync clears", 32'(underrun), 0);
        chk("R2 restart line", 32'(fill_line), 0);
        chk("R2 restart slot", 32'(fill_slot), 0);
        chk("R2 restart req", 32'(fill_req), 1);
        chk("R6 vsync slot", 32'(stream_slot), 3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule